// File: doc/BRIEF.md
# Set/Clear GPIO Port Register File

This block is a general-purpose I/O port of up to 32 lines that sits behind a simple 32-bit memory-mapped register bus with single-cycle read and write strobes. It holds two state words: output data and direction. Software never writes these words directly. Each word has a write-one-to-set register and a write-one-to-clear register. Several agents can therefore change different lines without a read-modify-write sequence and without racing each other.

The port drives every line's pad output value and output enable. The enable is high only for lines whose direction bit marks them as outputs. Pin levels are brought in through a two-flop synchronizer and can be read back together with the direction word. Read data is registered and appears the cycle after the read strobe. The design has no state machine: its only state is the two words, the synchronizer stages and the read-data register. A read is a single transition from idle to data valid and back.

Top module: `gpio_sc_port`

## Requirements
- R1: A write to offset 0x000 sets every output-data bit at whose position the write data holds a 1. Bits written as 0 keep their value. The new value appears on `pin_out` in the cycle after the write strobe.
- R2: A write to offset 0x004 clears every output-data bit at whose position the write data holds a 1. Bits written as 0 keep their value.
- R3: A write to offset 0x010 sets direction bits and a write to offset 0x014 clears them, both bitwise write-one. A direction bit of 1 makes the line an output, and `pin_oe[i]` equals direction bit i.
- R4: A read of offset 0x018 returns the current direction word, with bit i for line i.
- R5: A read of offset 0x080 returns the pin levels after a two-flop synchronizer. A level held on `pin_in` for two clock edges is returned by a read strobed on the next edge.
- R6: Reads of the write-only offsets 0x000, 0x004, 0x010 and 0x014, and reads of any unmapped offset (including offsets not a multiple of 4), return zero.
- R7: Writes to any offset other than 0x000, 0x004, 0x010 and 0x014 change neither the output data nor the direction.
- R8: After reset, output data and direction are all zero, so every line is an input and `bus_rdata` is zero.
- R9: `bus_rdata` is valid in the cycle after the read strobe and is zero in any cycle that does not follow a read strobe.
- R10: `pin_out` always presents the output-data word, whatever the direction, so a line can be preloaded before it is turned into an output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_rd | input | 1 | Single-cycle read strobe |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wdata | input | 32 | Write data, one bit per line |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | 32 | Raw pad input levels |
| pin_out | output | 32 | Pad output values |
| pin_oe | output | 32 | Pad output enables |

## Verification
A write is seen on `pin_out` and `pin_oe` one edge after its strobe. A read result appears on `bus_rdata` one edge after the read strobe. A pin level is readable only through a read strobed on the third edge after the pin changed. The bench drives every input at the falling edge and samples outputs at the next falling edge, so each sample falls in the cycle its result is due. Every pin change is followed by two idle edges before a pin read. Random mixes of set, clear, read and stray-offset accesses are compared with bench model words; directed cases cover reset, stray-offset writes and unaligned reads.

// File: rtl/gpio_sc_pkg.sv
package gpio_sc_pkg;
    localparam int ADDR_W   = 8;
    localparam int DATA_W   = 32;
    localparam int MAX_LINES = 32;

    localparam logic [ADDR_W-1:0] OFS_DATA_SET = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_DATA_CLR = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_DIR_SET  = 8'h10;
    localparam logic [ADDR_W-1:0] OFS_DIR_CLR  = 8'h14;
    localparam logic [ADDR_W-1:0] OFS_DIR_VIEW = 8'h18;
    localparam logic [ADDR_W-1:0] OFS_PIN_VIEW = 8'h80;

    typedef enum logic [2:0] {
        ACC_NONE,
        ACC_DATA_SET,
        ACC_DATA_CLR,
        ACC_DIR_SET,
        ACC_DIR_CLR,
        ACC_DIR_VIEW,
        ACC_PIN_VIEW
    } acc_kind_e;
endpackage

// File: rtl/gpio_sc_sync.sv
module gpio_sc_sync #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] raw_in,
    output logic [WIDTH-1:0] safe_out
);
    logic [WIDTH-1:0] stage1_q;
    logic [WIDTH-1:0] stage2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= raw_in;
            stage2_q <= stage1_q;
        end
    end

    assign safe_out = stage2_q;

    logic [1:0] age_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              age_q <= '0;
        else if (age_q != 2'd3)  age_q <= age_q + 2'd1;
    end

    AST_SYNC_TWO_EDGES: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 2'd3) |-> (safe_out == $past(raw_in, 2))); // R5
endmodule

// File: rtl/gpio_sc_bits.sv
module gpio_sc_bits #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_en,
    input  logic             clr_en,
    input  logic [WIDTH-1:0] mask,
    output logic [WIDTH-1:0] state
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      state <= '0;
        else if (set_en) state <= state | mask;
        else if (clr_en) state <= state & ~mask;
    end

    AST_SET_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
        set_en |=> ((state & $past(mask)) == $past(mask))); // R1
    AST_SET_KEEPS_OTHERS: assert property (@(posedge clk) disable iff (!rst_n)
        set_en |=> (((state ^ $past(state)) & ~$past(mask)) == '0)); // R1
    AST_CLR_LOWERS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && !set_en) |=> ((state & $past(mask)) == '0)); // R2
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_en && !clr_en) |=> $stable(state)); // R7
endmodule

// File: rtl/gpio_sc_port.sv
module gpio_sc_port
    import gpio_sc_pkg::*;
#(
    parameter int LINES = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [LINES-1:0]  pin_in,
    output logic [LINES-1:0]  pin_out,
    output logic [LINES-1:0]  pin_oe
);
    initial begin
        assert (LINES >= 1 && LINES <= MAX_LINES);
    end

    acc_kind_e        kind;
    logic [LINES-1:0] data_q;
    logic [LINES-1:0] dir_q;
    logic [LINES-1:0] pins_sync;
    logic [LINES-1:0] line_mask;
    logic [DATA_W-1:0] rd_next;
    logic [DATA_W-1:0] rdata_q;

    assign line_mask = bus_wdata[LINES-1:0];

    always_comb begin
        unique case (bus_addr)
            OFS_DATA_SET: kind = ACC_DATA_SET;
            OFS_DATA_CLR: kind = ACC_DATA_CLR;
            OFS_DIR_SET:  kind = ACC_DIR_SET;
            OFS_DIR_CLR:  kind = ACC_DIR_CLR;
            OFS_DIR_VIEW: kind = ACC_DIR_VIEW;
            OFS_PIN_VIEW: kind = ACC_PIN_VIEW;
            default:      kind = ACC_NONE;
        endcase
    end

    gpio_sc_bits #(.WIDTH(LINES)) u_data (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_en (bus_wr && kind == ACC_DATA_SET),
        .clr_en (bus_wr && kind == ACC_DATA_CLR),
        .mask   (line_mask),
        .state  (data_q)
    );

    gpio_sc_bits #(.WIDTH(LINES)) u_dir (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_en (bus_wr && kind == ACC_DIR_SET),
        .clr_en (bus_wr && kind == ACC_DIR_CLR),
        .mask   (line_mask),
        .state  (dir_q)
    );

    gpio_sc_sync #(.WIDTH(LINES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .raw_in   (pin_in),
        .safe_out (pins_sync)
    );

    always_comb begin
        rd_next = '0;
        if (bus_rd) begin
            unique case (kind)
                ACC_DIR_VIEW: rd_next[LINES-1:0] = dir_q;
                ACC_PIN_VIEW: rd_next[LINES-1:0] = pins_sync;
                default:      rd_next = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rdata_q <= '0;
        else        rdata_q <= rd_next;
    end

    assign bus_rdata = rdata_q;
    assign pin_out   = data_q;
    assign pin_oe    = dir_q;

    AST_IDLE_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> (bus_rdata == '0)); // R9
    AST_STRAY_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && kind != ACC_DIR_VIEW && kind != ACC_PIN_VIEW) |=> (bus_rdata == '0)); // R6
    AST_DIR_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == OFS_DIR_VIEW) |=> (bus_rdata[LINES-1:0] == $past(pin_oe))); // R4
    AST_STRAY_WRITE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr != OFS_DATA_SET && bus_addr != OFS_DATA_CLR
         && bus_addr != OFS_DIR_SET && bus_addr != OFS_DIR_CLR)
        |=> ($stable(pin_out) && $stable(pin_oe))); // R7
endmodule

// File: tb/gpio_sc_port_test.sv
module gpio_sc_port_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pin_in = '0;
    logic [31:0] pin_out;
    logic [31:0] pin_oe;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [31:0] m_data = '0;
    logic [31:0] m_dir  = '0;

    always #4 clk = ~clk;

    gpio_sc_port uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, got, exp);
        end
    endtask

    function automatic logic [31:0] model_write(input logic [7:0] a, input logic [31:0] v,
                                                input logic [31:0] cur_data, input logic [31:0] cur_dir,
                                                input bit want_dir);
        logic [31:0] d = cur_data;
        logic [31:0] r = cur_dir;
        case (a)
            8'h00: d = d | v;
            8'h04: d = d & ~v;
            8'h10: r = r | v;
            8'h14: r = r & ~v;
            default: ;
        endcase
        return want_dir ? r : d;
    endfunction

    function automatic logic [31:0] model_read(input logic [7:0] a);
        case (a)
            8'h18:   return m_dir;
            8'h80:   return pin_in;
            default: return 32'h0;
        endcase
    endfunction

    task automatic bus_write(input logic [7:0] a, input logic [31:0] v);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = v;
        @(negedge clk);
        bus_wr = 1'b0;
        m_data = model_write(a, v, m_data, m_dir, 1'b0);
        m_dir  = model_write(a, v, m_data, m_dir, 1'b1);
        check("R1/R2/R10 pin_out", pin_out, m_data);
        check("R3 pin_oe", pin_oe, m_dir);
    endtask

    task automatic bus_read(input logic [7:0] a, input string req);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        check(req, bus_rdata, model_read(a));
    endtask

    task automatic drive_pins(input logic [31:0] v);
        @(negedge clk);
        pin_in = v;
        @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        logic [7:0] addrs [10];
        int unused_seed;
        addrs = '{8'h00, 8'h04, 8'h10, 8'h14, 8'h18, 8'h80, 8'h08, 8'h84, 8'h81, 8'h7c};
        unused_seed = $urandom(32'd2024);

        repeat (3) @(negedge clk);
        // R8 reset state
        check("R8 pin_out", pin_out, 32'h0);
        check("R8 pin_oe", pin_oe, 32'h0);
        check("R8 rdata", bus_rdata, 32'h0);
        rst_n = 1'b1;
        bus_read(8'h18, "R8 dir after reset");

        // R1 set data, R10 visible while input
        bus_write(8'h00, 32'h0000_00F0);
        check("R10 data while input", pin_out, 32'h0000_00F0);
        bus_write(8'h00, 32'h8000_0001);
        // R2 clear data
        bus_write(8'h04, 32'h0000_0030);
        check("R2 partial clear", pin_out, 32'h8000_00C1);
        // R3 direction
        bus_write(8'h10, 32'hFFFF_0000);
        bus_write(8'h14, 32'h0F00_0000);
        check("R3 oe", pin_oe, 32'hF0FF_0000);
        // R4 readback
        bus_read(8'h18, "R4 dir read");
        // R9 rdata returns to zero the cycle after
        @(negedge clk);
        check("R9 idle rdata", bus_rdata, 32'h0);
        // R6 write-only and unaligned reads
        bus_read(8'h00, "R6 read data-set");
        bus_read(8'h14, "R6 read dir-clear");
        bus_read(8'h19, "R6 unaligned");
        // R7 stray writes ignored
        bus_write(8'h18, 32'hFFFF_FFFF);
        bus_write(8'h80, 32'hFFFF_FFFF);
        bus_write(8'h08, 32'hFFFF_FFFF);
        check("R7 data held", pin_out, 32'h8000_00C1);
        bus_read(8'h18, "R7 dir held");
        // R5 synchronized pins
        drive_pins(32'hA5A5_5A5A);
        bus_read(8'h80, "R5 pin read");
        drive_pins(32'hFFFF_FFFF);
        bus_read(8'h80, "R5 pins all ones");

        for (int i = 0; i < 300; i++) begin
            int op;
            op = $urandom_range(0, 9);
            if (op < 5)
                bus_write(addrs[$urandom_range(0, 9)], $urandom());
            else if (op < 9)
                bus_read(addrs[$urandom_range(0, 9)], "R4/R5/R6 random read");
            else
                drive_pins($urandom());
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule